// File: doc/BRIEF.md
# I2C Write Slave with Per-Byte Validated Acknowledge

This block is an I2C target that only receives. It watches the two bus lines through a synchroniser running on the system clock and spots START and STOP conditions. It takes in a 7-bit address followed by a direction bit. It acknowledges only a write to its own address. After that it shifts in data bytes. The acknowledge on a data byte is not automatic. As soon as the eighth bit is in, the block presents the byte with a one-cycle ready strobe. Logic next to the block then has until SCL falls after that eighth bit to return a verdict: accept or reject.

An accepted byte gets an ACK. A rejected byte, or one with no verdict in time, leaves SDA released, so the master sees a NACK. After a NACK the block stays silent until the next START or STOP. The block never drives SDA high. Its single output is a pull-low enable meant for an open-drain pad.

Top module: `i2c_vack_slave`

## Requirements
- R1: A START (SDA falls while SCL is high) begins a fresh address phase from any state, even in the middle of a byte. A STOP (SDA rises while SCL is high) returns the block to idle from any state. Both release SDA. In idle, bits are ignored until a START.
- R2: Address bits are taken MSB first on SCL rising edges, with the direction bit last (0 = write). If the 7 address bits equal `own_addr` and the direction bit is 0, `sda_oe` is 1 throughout the ninth SCL clock (ACK).
- R3: If the address does not match, or the direction bit is 1 (read), SDA stays released on the ninth clock (NACK). All later bits are then ignored until a START or STOP.
- R4: For each data byte of an acknowledged write, `rx_ready` pulses high for one cycle after the eighth SCL rising edge. On that cycle `rx_data` holds the byte, MSB first. `rx_ready` never pulses for address bytes or for partial bytes.
- R5: A verdict with `verdict_valid`=1 and `verdict_accept`=1, given from the `rx_ready` cycle up to the cycle in which the falling SCL edge after bit 8 is detected, produces an ACK. If several verdicts arrive in that window, the first one decides.
- R6: A verdict with `verdict_accept`=0 in the same window produces a NACK.
- R7: If no verdict arrives before that falling edge, the byte gets a NACK. A verdict that arrives later has no effect.
- R8: After a data-byte NACK, further bytes get neither an ACK nor an `rx_ready` pulse until a START or STOP.
- R9: `sda_oe` is released on the falling SCL edge that ends the ninth clock. After an ACK the next eight bits form the next data byte, so writes of several bytes work.
- R10: During and right after reset, `sda_oe` and `rx_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level (wired bus value) |
| own_addr | input | 7 | Address this target answers to |
| sda_oe | output | 1 | 1 = pull SDA low (open-drain enable) |
| rx_data | output | 8 | Last received data byte |
| rx_ready | output | 1 | One-cycle strobe: new data byte in `rx_data` |
| verdict_valid | input | 1 | Verdict strobe for the pending byte |
| verdict_accept | input | 1 | Verdict value: 1 accept, 0 reject |

## Verification
Each line edge reaches the logic two clocks after it happens on the pins, and takes effect in the following register. So `rx_ready` appears three clocks after the master's eighth SCL rise, and `sda_oe` changes three clocks after an SCL fall. The bench keeps each SCL half-period at six clocks and reads SDA in the middle of the high phase, well after the acknowledge has settled. It checks the release of `sda_oe` five clocks after the final fall, and counts `rx_ready` pulses at falling clock edges. In-time verdicts land one clock after the strobe. Late verdicts land ten clocks after it, which is past the detected falling edge.

// File: rtl/i2c_vack_pkg.sv
// Shared types for the validated-acknowledge I2C write slave.
// Assumes: one receive engine per slave; states are encoded compactly.
package i2c_vack_pkg;

    // Receive engine state.
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,  // wait for START
        ST_ADDR     = 3'd1,  // shifting address + direction
        ST_ADDR_ACK = 3'd2,  // ninth clock of the address byte
        ST_DATA     = 3'd3,  // shifting a data byte
        ST_DATA_ACK = 3'd4,  // ninth clock of a data byte
        ST_SKIP     = 3'd5   // refused: ignore bits until START/STOP
    } rx_state_t;

endpackage

// File: rtl/vack_sync.sv
// Multi-stage synchroniser for a group of asynchronous lines.
// Assumes: lines idle high, so every stage resets to 1.
module vack_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] pipe;

    // Shift the raw lines through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '1;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/vack_bus_events.sv
// Edge and bus-condition detector on the synchronised SCL/SDA.
// Assumes: inputs are already synchronised; previous values reset to idle-high.
module vack_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    // Hold the previous sample of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Compare the current sample with the previous one.
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

    assert_no_scl_edge_on_cond_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |-> !(scl_rise || scl_fall));

endmodule

// File: rtl/vack_verdict_latch.sv
// Captures the first accept/reject verdict given while the byte window is open.
// Assumes: window_open is high from the ready strobe until the deciding SCL fall.
// A verdict arriving on the deciding cycle itself still counts.
module vack_verdict_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic window_open,
    input  logic verdict_valid,
    input  logic verdict_accept,
    output logic ack_now
);

    logic seen;
    logic accepted;

    // Record the first verdict in the window; clear when the window shuts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen     <= 1'b0;
            accepted <= 1'b0;
        end else if (!window_open) begin
            seen     <= 1'b0;
            accepted <= 1'b0;
        end else if (verdict_valid && !seen) begin
            seen     <= 1'b1;
            accepted <= verdict_accept;
        end
    end

    // Decision offered to the engine: the held verdict, else a same-cycle one.
    always_comb begin
        if (seen) begin
            ack_now = accepted;
        end else begin
            ack_now = window_open & verdict_valid & verdict_accept;
        end
    end

    assert_first_verdict_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && window_open) |=> (!seen || accepted == $past(accepted)));

    assert_no_verdict_no_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen && !verdict_valid) |-> !ack_now);

endmodule

// File: rtl/vack_rx_engine.sv
// Receive state machine: address match, byte shifting, acknowledge drive.
// Assumes: event inputs come from the synchronised lines; START/STOP outrank
// everything; the acknowledge is set on the SCL fall after bit 8 and released
// on the SCL fall that ends the ninth clock.
module vack_rx_engine
    import i2c_vack_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-2:0] own_addr,
    input  logic              ack_now,
    output logic              window_open,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready
);

    localparam int                ADDR_W = BYTE_W - 1;
    localparam int                CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0]  LAST   = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0]  PENULT = CNT_W'(BYTE_W - 1);

    rx_state_t         state;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              ack_given;
    logic              addr_ok;
    logic [BYTE_W-1:0] next_shreg;

    // Address match: upper bits equal own address and direction is write.
    always_comb begin
        addr_ok    = (shreg[BYTE_W-1:1] == own_addr[ADDR_W-1:0]) && !shreg[0];
        next_shreg = {shreg[BYTE_W-2:0], sda_s};
    end

    // Verdict window: full data byte held, waiting for the deciding SCL fall.
    assign window_open = (state == ST_DATA) && (bitcnt == LAST);

    // Main sequencer for bits, acknowledge and bus conditions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            ack_given <= 1'b0;
            sda_oe    <= 1'b0;
            rx_data   <= '0;
            rx_ready  <= 1'b0;
        end else begin
            rx_ready <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_DATA: begin
                        if (scl_rise && bitcnt != LAST) begin
                            shreg  <= next_shreg;
                            bitcnt <= bitcnt + 1'b1;
                            if (state == ST_DATA && bitcnt == PENULT) begin
                                rx_ready <= 1'b1;
                                rx_data  <= next_shreg;
                            end
                        end else if (scl_fall && bitcnt == LAST) begin
                            if (state == ST_ADDR) begin
                                sda_oe    <= addr_ok;
                                ack_given <= addr_ok;
                                state     <= ST_ADDR_ACK;
                            end else begin
                                sda_oe    <= ack_now;
                                ack_given <= ack_now;
                                state     <= ST_DATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK, ST_DATA_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= ack_given ? ST_DATA : ST_SKIP;
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    assert_start_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && bitcnt == '0 && !sda_oe));

    assert_stop_idles_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state == ST_IDLE && !sda_oe));

    assert_addr_decision_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && scl_fall && bitcnt == LAST && !start_det && !stop_det)
        |=> (sda_oe == $past(addr_ok)));

    assert_refused_goes_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK && !ack_given && scl_fall && !start_det && !stop_det)
        |=> (state == ST_SKIP));

    assert_ready_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |=> !rx_ready);

    assert_ready_opens_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> window_open);

    assert_skip_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (!sda_oe && !rx_ready));

    assert_oe_only_in_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state == ST_ADDR_ACK || state == ST_DATA_ACK));

    assert_release_after_ninth_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ADDR_ACK || state == ST_DATA_ACK) && scl_fall) |=> !sda_oe);

endmodule

// File: rtl/i2c_vack_slave.sv
// I2C write-only slave whose data-byte acknowledge follows an external verdict.
// Assumes: no clock stretching, 7-bit addressing, single master; SDA output is
// an open-drain pull-low enable only.
module i2c_vack_slave #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [BYTE_W-2:0] own_addr,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    input  logic              verdict_valid,
    input  logic              verdict_accept
);

    logic [1:0] lines_s;
    logic       scl_s;
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic       window_open;
    logic       ack_now;

    vack_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_in, sda_in}),
        .dout (lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    vack_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    vack_verdict_latch u_verdict (
        .clk           (clk),
        .rst_n         (rst_n),
        .window_open   (window_open),
        .verdict_valid (verdict_valid),
        .verdict_accept(verdict_accept),
        .ack_now       (ack_now)
    );

    vack_rx_engine #(.BYTE_W(BYTE_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .own_addr   (own_addr),
        .ack_now    (ack_now),
        .window_open(window_open),
        .sda_oe     (sda_oe),
        .rx_data    (rx_data),
        .rx_ready   (rx_ready)
    );

endmodule

// File: tb/i2c_vack_slave_bench.sv
module i2c_vack_slave_bench;

    localparam int         HALF = 6;
    localparam logic [6:0] OWN  = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       bus_sda;
    logic       sda_oe;
    logic [7:0] rx_data;
    logic       rx_ready;
    logic       verdict_valid = 1'b0;
    logic       verdict_accept = 1'b0;

    int errors = 0;
    int checks = 0;
    int ready_cnt = 0;
    logic [7:0] last_byte = 8'h00;
    bit   resp_en = 1'b1;
    int   resp_delay = 1;
    bit   reported = 1'b0;

    assign bus_sda = m_sda & ~sda_oe;

    always #5 clk = ~clk;

    i2c_vack_slave u_i2c_vack_slave (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_in        (m_scl),
        .sda_in        (bus_sda),
        .own_addr      (OWN),
        .sda_oe        (sda_oe),
        .rx_data       (rx_data),
        .rx_ready      (rx_ready),
        .verdict_valid (verdict_valid),
        .verdict_accept(verdict_accept)
    );

    function automatic bit accept_rule(input logic [7:0] d);
        return (int'(d) % 3) != 0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_clks(HALF);
        m_scl = 1'b1; wait_clks(HALF);
        m_sda = 1'b0; wait_clks(HALF);
        m_scl = 1'b0; wait_clks(2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_clks(HALF);
        m_scl = 1'b1; wait_clks(HALF);
        m_sda = 1'b1; wait_clks(HALF);
    endtask

    task automatic send_bit(input logic b, output logic s);
        m_sda = b;    wait_clks(HALF);
        m_scl = 1'b1; wait_clks(HALF / 2);
        s = bus_sda;  wait_clks(HALF - HALF / 2);
        m_scl = 1'b0; wait_clks(2);
    endtask

    // Returns the ninth-clock SDA level: 0 = ACK, 1 = NACK.
    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) send_bit(b[i], s);
        send_bit(1'b1, ack);
    endtask

    // Count ready strobes and remember the byte.
    initial begin
        forever begin
            @(negedge clk);
            if (rx_ready) begin
                ready_cnt++;
                last_byte = rx_data;
            end
        end
    end

    // Verdict responder applying the arithmetic rule after a chosen delay.
    initial begin
        forever begin
            @(negedge clk);
            if (rx_ready && resp_en) begin
                logic [7:0] got;
                got = rx_data;
                repeat (resp_delay) @(negedge clk);
                verdict_valid  = 1'b1;
                verdict_accept = accept_rule(got);
                @(negedge clk);
                verdict_valid  = 1'b0;
                verdict_accept = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        logic ack;
        int   c0;
        wait_clks(5);
        check("R10 sda_oe in reset", int'(sda_oe), 0);
        check("R10 rx_ready in reset", int'(rx_ready), 0);
        rst_n = 1'b1;
        wait_clks(3);
        check("R10 sda_oe after reset", int'(sda_oe), 0);

        // R2/R3: every address with write direction.
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({7'(a), 1'b0}, ack);
            check((a == int'(OWN)) ? "R2 own address ACK" : "R3 foreign address NACK",
                  int'(ack), (a == int'(OWN)) ? 0 : 1);
            bus_stop();
        end

        // R3: read direction refused, following byte ignored.
        bus_start();
        send_byte({OWN, 1'b1}, ack);
        check("R3 read bit NACK", int'(ack), 1);
        c0 = ready_cnt;
        send_byte(8'h55, ack);
        check("R3 bits after refusal NACK", int'(ack), 1);
        check("R3 no strobe after refusal", ready_cnt, c0);
        bus_stop();

        // R4/R5/R6: sweep all data values, one per transfer.
        for (int d = 0; d < 256; d++) begin
            bus_start();
            send_byte({OWN, 1'b0}, ack);
            c0 = ready_cnt;
            send_byte(8'(d), ack);
            check("R4 one strobe per byte", ready_cnt, c0 + 1);
            check("R4 byte value", int'(last_byte), d);
            check(accept_rule(8'(d)) ? "R5 accept gives ACK" : "R6 reject gives NACK",
                  int'(ack), accept_rule(8'(d)) ? 0 : 1);
            bus_stop();
        end

        // R7: late verdict and missing verdict both NACK.
        resp_delay = 10;
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        send_byte(8'h01, ack);
        check("R7 late verdict NACK", int'(ack), 1);
        bus_stop();
        resp_delay = 1;
        resp_en = 1'b0;
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        send_byte(8'h02, ack);
        check("R7 no verdict NACK", int'(ack), 1);
        bus_stop();
        resp_en = 1'b1;

        // R8: after a data NACK nothing is taken until START.
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        send_byte(8'h03, ack);
        check("R8 rejected byte NACK", int'(ack), 1);
        c0 = ready_cnt;
        send_byte(8'h01, ack);
        check("R8 ignored byte NACK", int'(ack), 1);
        check("R8 ignored byte no strobe", ready_cnt, c0);
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        check("R8 START revives", int'(ack), 0);
        bus_stop();

        // R9: several bytes in one write, release after each ninth clock.
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        c0 = ready_cnt;
        send_byte(8'h01, ack);
        check("R9 byte1 ACK", int'(ack), 0);
        wait_clks(3);
        check("R9 release after ninth clock", int'(sda_oe), 0);
        send_byte(8'h02, ack);
        check("R9 byte2 ACK", int'(ack), 0);
        send_byte(8'h04, ack);
        check("R9 byte3 ACK", int'(ack), 0);
        check("R9 three strobes", ready_cnt, c0 + 3);
        check("R9 last byte", int'(last_byte), 4);
        wait_clks(3);
        check("R9 released at end", int'(sda_oe), 0);
        bus_stop();

        // R1: repeated START mid-byte restarts the address phase.
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        c0 = ready_cnt;
        for (int i = 0; i < 4; i++) begin
            logic s;
            send_bit(1'b1, s);
        end
        bus_start();
        send_byte({OWN, 1'b0}, ack);
        check("R1 repeated START address ACK", int'(ack), 0);
        send_byte(8'h05, ack);
        check("R1 byte after restart ACK", int'(ack), 0);
        check("R1 only full byte strobed", ready_cnt, c0 + 1);
        check("R1 byte after restart value", int'(last_byte), 5);

        // R1: STOP mid-byte goes idle; bits without START are ignored.
        for (int i = 0; i < 3; i++) begin
            logic s;
            send_bit(1'b0, s);
        end
        bus_stop();
        c0 = ready_cnt;
        m_scl = 1'b0;
        wait_clks(2);
        send_byte({OWN, 1'b0}, ack);
        check("R1 idle ignores address", int'(ack), 1);
        send_byte(8'h01, ack);
        check("R1 idle no strobe", ready_cnt, c0);
        bus_stop();

        report();
    end

endmodule